// File: doc/BRIEF.md
# Extended Control Register Access Unit

This unit carries out get and set operations on the extended control register whose bits select which processor state components are enabled. A request arrives as one cycle with `op_valid` high. It carries:

- the operation kind;
- a register index;
- a 64-bit write value split into high and low halves;
- the current privilege level;
- a flag for real or virtual-8086 mode;
- the OS-enable bit taken from the control register.

The unit checks the request in a fixed priority order. It then either returns the register contents, updates the register, or raises exactly one of two faults: undefined opcode or general protection.

Only index 0 exists. The parameter `SUPPORTED` is a mask of the bits software may turn on. Bit 0 must always stay set. The upper 32 bits of the register are always zero.

Results are registered. The fault pulses and the read data appear in the cycle after the request is sampled. A successful set becomes visible on `xcr_value` in that same following cycle.

Top module: `xcr_access_unit`

## Requirements
- R1: While `rst_n` is low and after its release, `xcr_value` is 1, `rd_data` is 0, and both fault outputs are 0.
- R2: A request of either kind with `os_enable` = 0 raises `ud_fault` in the next cycle and leaves the register unchanged. `op_is_set` = 1 means set and 0 means get.
- R3: A set with `legacy_mode` = 1 raises `ud_fault`. This holds even when `os_enable` is 0 or the privilege level is nonzero, because this check comes first.
- R4: A set that is not in legacy mode, with `os_enable` = 1 and `cpl` other than 0, raises `gp_fault`. This holds even when the index or the value is also bad.
- R5: Any `op_index` other than 0, on a get or on a set that passes the earlier checks, raises `gp_fault`.
- R6: A set whose `wr_hi` is nonzero raises `gp_fault`.
- R7: A set whose `wr_lo` has a 1 in a bit that is 0 in `SUPPORTED` raises `gp_fault`. The default mask is 0x7.
- R8: A set whose `wr_lo` bit 0 is 0 raises `gp_fault`, so `xcr_value` bit 0 is always 1.
- R9: A set that raises no fault loads `{wr_hi, wr_lo}` into the register, visible on `xcr_value` in the next cycle. A get issued in the cycle after it returns the new value.
- R10: A get with `os_enable` = 1 and index 0 raises no fault, whatever `cpl` and `legacy_mode` are. In the next cycle it places the current register value on `rd_data`.
- R11: At most one fault output is high in any cycle. A fault is high for exactly one cycle and only after a request. Idle cycles raise no fault and leave the register unchanged.
- R12: `rd_data` changes only after a get that raises no fault. Sets and faulted gets leave it holding its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | Request present this cycle |
| op_is_set | input | 1 | 1 = set, 0 = get |
| op_index | input | 32 | Register index |
| wr_hi | input | 32 | Upper half of the write value |
| wr_lo | input | 32 | Lower half of the write value |
| cpl | input | 2 | Current privilege level |
| legacy_mode | input | 1 | Real or virtual-8086 mode |
| os_enable | input | 1 | OS-enable bit from the control register |
| rd_data | output | 64 | Value returned by the last successful get |
| ud_fault | output | 1 | Undefined-opcode fault pulse |
| gp_fault | output | 1 | General-protection fault pulse |
| xcr_value | output | 64 | Current register contents |

## Verification
Several fault conditions can fall on the same request. The ones that matter most are:

- legacy mode together with a cleared OS-enable bit;
- a nonzero privilege level together with a bad index and reserved value bits.

The bench builds such requests on purpose. It checks that only the highest-priority fault appears and that the register stays untouched.

A successful set followed at once by a get is also checked. It confirms that the read in the next cycle sees the value just written, judged against a reference model in the bench on every clock.

// File: rtl/xcr_pkg.sv
package xcr_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2
  } fault_e;

  typedef struct packed {
    fault_e fault;
    logic   write_ok;
    logic   read_ok;
  } verdict_t;

endpackage

// File: rtl/xcr_check.sv
module xcr_check
  import xcr_pkg::*;
#(
  parameter int unsigned IDX_W = 32,
  parameter int unsigned CPL_W = 2,
  parameter int unsigned HALF  = 32,
  parameter logic [HALF-1:0] SUPPORTED = 'h7
) (
  input  logic             op_valid,
  input  logic             op_is_set,
  input  logic [IDX_W-1:0] op_index,
  input  logic [HALF-1:0]  wr_hi,
  input  logic [HALF-1:0]  wr_lo,
  input  logic [CPL_W-1:0] cpl,
  input  logic             legacy_mode,
  input  logic             os_enable,
  output verdict_t         verdict
);

  logic hi_bad;
  logic lo_bad;
  logic base_bad;
  logic value_bad;
  logic index_bad;
  logic priv_bad;

  always_comb begin
    hi_bad    = |wr_hi;
    lo_bad    = |(wr_lo & ~SUPPORTED);
    base_bad  = ~wr_lo[0];
    value_bad = hi_bad | lo_bad | base_bad;
    index_bad = |op_index;
    priv_bad  = |cpl;
  end

  // Priority chain: mode, OS enable, privilege, index, value.
  always_comb begin
    verdict.fault    = FLT_NONE;
    verdict.write_ok = 1'b0;
    verdict.read_ok  = 1'b0;
    if (op_valid) begin
      if (op_is_set) begin
        if (legacy_mode)     verdict.fault = FLT_UD;
        else if (!os_enable) verdict.fault = FLT_UD;
        else if (priv_bad)   verdict.fault = FLT_GP;
        else if (index_bad)  verdict.fault = FLT_GP;
        else if (value_bad)  verdict.fault = FLT_GP;
        else                 verdict.write_ok = 1'b1;
      end else begin
        if (!os_enable)      verdict.fault = FLT_UD;
        else if (index_bad)  verdict.fault = FLT_GP;
        else                 verdict.read_ok = 1'b1;
      end
    end
  end

endmodule

// File: rtl/xcr_reg.sv
module xcr_reg #(
  parameter int unsigned HALF = 32,
  parameter logic [HALF-1:0] SUPPORTED = 'h7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            write_en,
  input  logic [HALF-1:0] wr_lo,
  output logic [HALF-1:0] value
);

  logic illegal_bits;

  always_comb illegal_bits = |(wr_lo & ~SUPPORTED);

  // Only bits present in the mask get a storage cell; the rest are tied low.
  for (genvar b = 0; b < HALF; b++) begin : g_bit
    if (SUPPORTED[b]) begin : g_cell
      logic d;
      logic q;
      always_comb d = write_en ? wr_lo[b] : q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= (b == 0) ? 1'b1 : 1'b0;
        else        q <= d;
      end
      assign value[b] = q;
    end else begin : g_tie
      assign value[b] = 1'b0;
    end
  end

  assert_clean_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    write_en |-> !illegal_bits);

  assert_base_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    value[0]);

endmodule

// File: rtl/xcr_resp.sv
module xcr_resp
  import xcr_pkg::*;
#(
  parameter int unsigned HALF = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  verdict_t        verdict,
  input  logic [HALF-1:0] cur_value,
  output logic            ud_q,
  output logic            gp_q,
  output logic [HALF-1:0] rd_q
);

  logic            ud_d;
  logic            gp_d;
  logic            rd_en;
  logic [HALF-1:0] rd_d;

  always_comb begin
    ud_d  = (verdict.fault == FLT_UD);
    gp_d  = (verdict.fault == FLT_GP);
    rd_en = verdict.read_ok;
    rd_d  = rd_en ? cur_value : rd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ud_q <= 1'b0;
      gp_q <= 1'b0;
      rd_q <= '0;
    end else begin
      ud_q <= ud_d;
      gp_q <= gp_d;
      rd_q <= rd_d;
    end
  end

  assert_single_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ud_q && gp_q));

endmodule

// File: rtl/xcr_access_unit.sv
module xcr_access_unit
  import xcr_pkg::*;
#(
  parameter int unsigned REG_W = 64,
  parameter int unsigned IDX_W = 32,
  parameter int unsigned CPL_W = 2,
  parameter logic [REG_W/2-1:0] SUPPORTED = 'h7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic             op_is_set,
  input  logic [IDX_W-1:0] op_index,
  input  logic [REG_W/2-1:0] wr_hi,
  input  logic [REG_W/2-1:0] wr_lo,
  input  logic [CPL_W-1:0] cpl,
  input  logic             legacy_mode,
  input  logic             os_enable,
  output logic [REG_W-1:0] rd_data,
  output logic             ud_fault,
  output logic             gp_fault,
  output logic [REG_W-1:0] xcr_value
);

  localparam int unsigned HALF = REG_W / 2;

  verdict_t        verdict;
  logic [HALF-1:0] cur_value;
  logic [HALF-1:0] rd_lo;

  xcr_check #(
    .IDX_W(IDX_W), .CPL_W(CPL_W), .HALF(HALF), .SUPPORTED(SUPPORTED)
  ) u_check (
    .op_valid(op_valid), .op_is_set(op_is_set), .op_index(op_index),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .cpl(cpl), .legacy_mode(legacy_mode),
    .os_enable(os_enable), .verdict(verdict)
  );

  xcr_reg #(.HALF(HALF), .SUPPORTED(SUPPORTED)) u_reg (
    .clk(clk), .rst_n(rst_n), .write_en(verdict.write_ok),
    .wr_lo(wr_lo), .value(cur_value)
  );

  xcr_resp #(.HALF(HALF)) u_resp (
    .clk(clk), .rst_n(rst_n), .verdict(verdict), .cur_value(cur_value),
    .ud_q(ud_fault), .gp_q(gp_fault), .rd_q(rd_lo)
  );

  assign rd_data   = {{HALF{1'b0}}, rd_lo};
  assign xcr_value = {{HALF{1'b0}}, cur_value};

  assert_os_off_ud_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !os_enable) |=> ud_fault);

  assert_legacy_ud_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_is_set && legacy_mode) |=> ud_fault);

  assert_priv_gp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_is_set && !legacy_mode && os_enable && (cpl != '0))
      |=> (gp_fault && $stable(xcr_value)));

  assert_high_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xcr_value[REG_W-1:HALF] == '0);

  assert_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xcr_value[HALF-1:0] & ~SUPPORTED) == '0);

  assert_get_ok_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_is_set && os_enable && (op_index == '0))
      |=> (!ud_fault && !gp_fault && rd_data == $past(xcr_value)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> (!ud_fault && !gp_fault && $stable(xcr_value)));

  assert_no_set_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_is_set) |=> $stable(xcr_value));

  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && !op_is_set && os_enable && (op_index == '0)) |=> $stable(rd_data));

endmodule

// File: tb/sim_xcr_access_unit.sv
`timescale 1ns/1ps
module sim_xcr_access_unit;

  // Supported mask used by the requirements (R7): 0x7.
  localparam logic [31:0] SUP = 32'h7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        d_valid, d_set, d_legacy, d_os;
  logic [31:0] d_idx, d_hi, d_lo;
  logic [1:0]  d_cpl;
  string       d_tag;
  logic [63:0] rd_data, xcr_value;
  logic        ud_fault, gp_fault;

  int checks = 0;
  int errs   = 0;
  int cycles = 0;

  xcr_access_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(d_valid), .op_is_set(d_set),
    .op_index(d_idx), .wr_hi(d_hi), .wr_lo(d_lo), .cpl(d_cpl),
    .legacy_mode(d_legacy), .os_enable(d_os), .rd_data(rd_data),
    .ud_fault(ud_fault), .gp_fault(gp_fault), .xcr_value(xcr_value)
  );

  always #4 clk = ~clk;

  // Reference model
  logic [63:0] m_xcr, m_rd;
  logic        m_ud, m_gp;
  string       m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_xcr = 64'd1; m_rd = 64'd0; m_ud = 0; m_gp = 0; m_tag = "R1";
    end else begin
      m_ud = 0; m_gp = 0; m_tag = d_tag;
      if (d_valid) begin
        if (d_set) begin
          if (d_legacy || !d_os) m_ud = 1;
          else if (d_cpl != 0 || d_idx != 0) m_gp = 1;
          else if (d_hi != 0 || (d_lo & ~SUP) != 0 || d_lo[0] == 0) m_gp = 1;
          else m_xcr = {d_hi, d_lo};
        end else begin
          if (!d_os) m_ud = 1;
          else if (d_idx != 0) m_gp = 1;
          else m_rd = m_xcr;
        end
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (ud_fault !== m_ud) begin
      errs++; $display("FAIL %s ud_fault actual=%0b expected=%0b", m_tag, ud_fault, m_ud);
    end
    checks++;
    if (gp_fault !== m_gp) begin
      errs++; $display("FAIL %s gp_fault actual=%0b expected=%0b", m_tag, gp_fault, m_gp);
    end
    checks++;
    if (rd_data !== m_rd) begin
      errs++; $display("FAIL %s rd_data actual=%h expected=%h", m_tag, rd_data, m_rd);
    end
    checks++;
    if (xcr_value !== m_xcr) begin
      errs++; $display("FAIL %s xcr_value actual=%h expected=%h", m_tag, xcr_value, m_xcr);
    end
  end

  task automatic op(input string tag, input logic s, input logic [31:0] idx,
                    input logic [31:0] hi, input logic [31:0] lo,
                    input logic [1:0] c, input logic lg, input logic os);
    @(negedge clk);
    d_tag = tag; d_valid = 1; d_set = s; d_idx = idx; d_hi = hi; d_lo = lo;
    d_cpl = c; d_legacy = lg; d_os = os;
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    d_tag = tag; d_valid = 0; d_set = 1; d_idx = 32'h5; d_hi = 32'hFFFF;
    d_lo = 32'h0; d_cpl = 2'd3; d_legacy = 1; d_os = 0;
  endtask

  initial begin
    rst_n = 0; d_tag = "R1"; d_valid = 0; d_set = 0; d_idx = 0; d_hi = 0;
    d_lo = 0; d_cpl = 0; d_legacy = 0; d_os = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle("R1"); idle("R1");

    op("R10", 0, 0, 0, 0, 0, 0, 1);         // read reset value
    op("R2", 1, 0, 0, 32'h3, 0, 0, 0);      // set with OS disabled
    op("R2", 0, 0, 0, 0, 0, 0, 0);          // get with OS disabled
    op("R3", 1, 0, 0, 32'h3, 2'd3, 1, 0);   // legacy wins over OS and CPL
    op("R3", 1, 7, 32'h1, 32'h3, 0, 1, 1);
    op("R4", 1, 5, 32'h1, 32'h8, 2'd3, 0, 1);
    op("R4", 1, 0, 0, 32'h3, 2'd1, 0, 1);
    op("R5", 1, 1, 0, 32'h3, 0, 0, 1);
    op("R5", 0, 32'h8000_0000, 0, 0, 0, 0, 1);
    op("R6", 1, 0, 32'h1, 32'h3, 0, 0, 1);
    op("R7", 1, 0, 0, 32'h9, 0, 0, 1);
    op("R8", 1, 0, 0, 32'h6, 0, 0, 1);
    op("R9", 1, 0, 0, 32'h3, 0, 0, 1);
    op("R9", 0, 0, 0, 0, 0, 0, 1);
    op("R9", 1, 0, 0, 32'h7, 0, 0, 1);
    op("R9", 0, 0, 0, 0, 0, 0, 1);          // back-to-back read of new value
    op("R10", 0, 0, 0, 0, 2'd3, 1, 1);      // get ignores CPL and mode
    idle("R11"); idle("R11"); idle("R11");
    op("R12", 1, 0, 0, 32'h1, 0, 0, 1);     // set: rd_data holds
    op("R12", 0, 3, 0, 0, 0, 0, 1);         // faulted get: rd_data holds
    op("R12", 0, 0, 0, 0, 0, 0, 0);
    op("R10", 0, 0, 0, 0, 2'd2, 0, 1);
    for (int v = 0; v < 20; v++) begin
      op("R7", 1, 0, 0, v, 0, 0, 1);
      op("R9", 0, 0, 0, 0, 0, 0, 1);
    end
    for (int k = 0; k < 16; k++) begin
      op("R11", k[0], {31'd0, k[1]}, 0, 32'h5, {1'b0, k[2]}, 0, k[3]);
      idle("R11");
    end
    idle("R11"); idle("R11");
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errs++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

endmodule